// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Squash

This block holds dispatched instructions for a small out-of-order core until they may go to execute. Each entry carries a sequence number, a non-speculative flag, a memory flag and a tag plus a ready bit for each source operand. Every entry sits in one of four pools. The waiting pool holds entries with outstanding sources. The schedulable pool holds entries that are ready to go. The non-speculative pool holds entries that only commit may release. The replay pool holds memory operations that have been parked for a retry.

Each clock the queue sends up to `ISSUE_W` entries to execute, oldest first. The issue outputs are registered. Writeback broadcasts a producer tag, and each matching source of every entry becomes ready. Commit releases a non-speculative entry by naming its sequence number. The load/store unit can park a memory operation and later replay every parked entry. A squash names a sequence number and removes every entry younger than it. All sequence-number comparisons use a wrap-aware difference, so the age order survives a counter rollover.

Top module: `ooo_issue_queue`

## Requirements
- R1: After reset the queue holds no entries: `occupancy` is 0, `full` is 0 and every `iss_valid` bit is 0.
- R2: An entry inserted without the non-speculative flag, and with every `ins_src_ok` bit set, is issued at the clock edge after its insert edge. Its `iss_valid` is visible after that edge. An entry with any source not ready is not issued.
- R3: A wakeup marks ready every source whose stored tag equals `wk_tag`. A waiting entry whose last source becomes ready this way is issued at the edge after the wakeup edge. A tag that matches no source has no effect.
- R4: At most `ISSUE_W` entries issue per clock, chosen oldest first. Output slot k (bits `[k*SEQ_W +: SEQ_W]` of `iss_seq`) carries the k-th oldest issued entry, so slot 0 is the oldest.
- R5: A non-speculative entry never issues on its own. A release whose `rel_seq` equals the sequence number of the oldest non-speculative entry issues that entry in slot 0 at the release edge. Schedulable entries fill only the remaining slots in that cycle. A release naming any other sequence number has no effect.
- R6: A squash with value S removes, at the squash edge, every entry in every pool whose sequence number is younger than S. An entry that would have issued at that edge is removed instead. An entry whose sequence number equals S, or is older, is kept.
- R7: A squash takes effect before a wakeup in the same cycle: a squashed entry never issues, even when that wakeup would have made it ready.
- R8: A parked memory entry (`park_valid`) enters the replay pool, counts toward occupancy and does not issue until `replay_go`. Every parked entry then becomes schedulable and issues with `iss_mem` set to 1.
- R9: `occupancy` rises by one for each accepted insert or park. It falls by one for each entry issued or squashed. `full` is 1 exactly when `occupancy` equals `DEPTH`.
- R10: Age is decided by the wrap-aware difference of sequence numbers, so 8'hFE and 8'hFF are older than 8'h01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ins_valid | input | 1 | Insert an entry from dispatch |
| ins_seq | input | SEQ_W | Sequence number of the inserted entry |
| ins_nspec | input | 1 | Inserted entry is non-speculative |
| ins_mem | input | 1 | Inserted entry is a memory operation |
| ins_src_tag | input | NSRC*TAG_W | Producer tag per source, source s at `[s*TAG_W +: TAG_W]` |
| ins_src_ok | input | NSRC | Source operand already ready, one bit per source |
| wk_valid | input | 1 | Wakeup broadcast valid |
| wk_tag | input | TAG_W | Producer tag being woken |
| rel_valid | input | 1 | Commit releases a non-speculative entry |
| rel_seq | input | SEQ_W | Sequence number named by the release |
| park_valid | input | 1 | Park a memory operation for replay |
| park_seq | input | SEQ_W | Sequence number of the parked entry |
| replay_go | input | 1 | Move all parked entries to the schedulable pool |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Squash point; younger entries are removed |
| iss_valid | output | ISSUE_W | Issue slot carries an entry (registered) |
| iss_seq | output | ISSUE_W*SEQ_W | Sequence number per issue slot |
| iss_mem | output | ISSUE_W | Memory flag per issue slot |
| occupancy | output | CNT_W | Number of entries held |
| full | output | 1 | Occupancy equals DEPTH |

## Verification
Some properties are checked on every cycle. The occupancy counter must agree with the number of valid entries. The selector must never grant more than the issue width, and it must never pass over an older candidate for a younger one. A release hit must appear in slot 0 on the next cycle. A squashed entry must leave its slot. After a squash without an insert in the same cycle, no entry younger than the squash point may remain. The directed scenarios show what those checks cannot: which sequence numbers come out in which slot across a rollover, that a release with a mismatched number and a wakeup with an unused tag change nothing, that a squash combined with a wakeup still lets the equal-numbered entry through, and that parked entries stay quiet until replay.

// File: rtl/iq_pkg.sv
// Package: shared types of the issue queue.
// Assumes: nothing beyond SystemVerilog 2017.
package iq_pkg;
    // Pool an entry currently lives in.
    typedef enum logic [1:0] {
        POOL_WAIT   = 2'd0,
        POOL_SCHED  = 2'd1,
        POOL_NSPEC  = 2'd2,
        POOL_REPLAY = 2'd3
    } pool_e;
endpackage

// File: rtl/iq_free_pick.sv
// Module: finds the lowest and the highest free entry of a busy mask.
// Assumes: the caller checks lo_any / hi_any before using the one-hot results.
module iq_free_pick #(
    parameter int DEPTH = 8
) (
    input  logic [DEPTH-1:0] busy,
    output logic [DEPTH-1:0] lo_oh,
    output logic [DEPTH-1:0] hi_oh,
    output logic             lo_any,
    output logic             hi_any
);
    // Scan upward for the first free entry.
    always_comb begin
        lo_oh  = '0;
        lo_any = 1'b0;
        for (int i = 0; i < DEPTH; i++) begin
            if (!busy[i] && !lo_any) begin
                lo_oh[i] = 1'b1;
                lo_any   = 1'b1;
            end
        end
    end

    // Scan downward for the last free entry.
    always_comb begin
        hi_oh  = '0;
        hi_any = 1'b0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!busy[i] && !hi_any) begin
                hi_oh[i] = 1'b1;
                hi_any   = 1'b1;
            end
        end
    end
endmodule

// File: rtl/iq_src_track.sv
// Module: source-readiness update for one entry under a wakeup broadcast.
// Assumes: one wakeup tag per cycle; tags are compared exactly.
module iq_src_track #(
    parameter int NSRC  = 2,
    parameter int TAG_W = 4
) (
    input  logic [NSRC*TAG_W-1:0] tags,
    input  logic [NSRC-1:0]       ok,
    input  logic                  wk_valid,
    input  logic [TAG_W-1:0]      wk_tag,
    output logic [NSRC-1:0]       ok_next,
    output logic                  all_ok
);
    for (genvar s = 0; s < NSRC; s++) begin : g_src
        // A source becomes ready when its producer tag is broadcast.
        assign ok_next[s] = ok[s] | (wk_valid && (tags[s*TAG_W +: TAG_W] == wk_tag));
    end

    assign all_ok = &ok_next;
endmodule

// File: rtl/iq_age_rank.sv
// Module: picks up to SLOTS oldest candidates by wrap-aware sequence age
//         and assigns them to output slots, optionally skipping slot 0.
// Assumes: live candidates carry distinct sequence numbers within half the
//          sequence space of each other.
module iq_age_rank #(
    parameter int DEPTH = 8,
    parameter int SEQ_W = 8,
    parameter int SLOTS = 2
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [DEPTH-1:0]       cand,
    input  logic [DEPTH*SEQ_W-1:0] seqs,
    input  logic                   skip_first,
    output logic [DEPTH-1:0]       grant,
    output logic [SLOTS*DEPTH-1:0] slot_oh
);
    localparam int RW = $clog2(DEPTH + 2) + 1;
    localparam logic [RW-1:0] SLOTS_R = RW'(SLOTS);

    logic [RW-1:0] pos [DEPTH];
    logic          skip_viol;

    // True when sequence a is older than sequence b; tie decides equal values.
    function automatic logic seq_older(input logic [SEQ_W-1:0] a,
                                       input logic [SEQ_W-1:0] b,
                                       input logic tie);
        logic [SEQ_W-1:0] d;
        d = a - b;
        return (d == '0) ? tie : d[SEQ_W-1];
    endfunction

    // Slot position of each entry: number of older candidates plus the skip.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            pos[i] = {{(RW-1){1'b0}}, skip_first};
            for (int j = 0; j < DEPTH; j++) begin
                if (j != i && cand[j] &&
                    seq_older(seqs[j*SEQ_W +: SEQ_W], seqs[i*SEQ_W +: SEQ_W], j < i))
                    pos[i] = pos[i] + 1'b1;
            end
        end
    end

    // Grant candidates whose position falls inside the slot budget.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            grant[i] = cand[i] && (pos[i] < SLOTS_R);
            for (int k = 0; k < SLOTS; k++)
                slot_oh[k*DEPTH + i] = grant[i] && (pos[i] == RW'(k));
        end
    end

    // Checker: a granted entry never has an older candidate left behind.
    always_comb begin
        skip_viol = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            for (int j = 0; j < DEPTH; j++)
                if (grant[i] && cand[j] && !grant[j] &&
                    seq_older(seqs[j*SEQ_W +: SEQ_W], seqs[i*SEQ_W +: SEQ_W], j < i))
                    skip_viol = 1'b1;
    end

    p_grant_cap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant) <= SLOTS);

    p_oldest_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !skip_viol);

    for (genvar k = 0; k < SLOTS; k++) begin : g_slot_chk
        p_slot_onehot_r4: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(slot_oh[k*DEPTH +: DEPTH]));
    end
endmodule

// File: rtl/ooo_issue_queue.sv
// Module: out-of-order issue queue with four entry pools (waiting,
//         schedulable, non-speculative, replay), oldest-first multi-issue,
//         commit release of non-speculative entries, memory replay and
//         age-based squash.
// Assumes: dispatch does not insert or park while full; sequence numbers of
//          live entries are distinct and within half the sequence space.
module ooo_issue_queue
    import iq_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int SEQ_W   = 8,
    parameter int TAG_W   = 4,
    parameter int NSRC    = 2,
    parameter int ISSUE_W = 2,
    localparam int CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ins_valid,
    input  logic [SEQ_W-1:0]         ins_seq,
    input  logic                     ins_nspec,
    input  logic                     ins_mem,
    input  logic [NSRC*TAG_W-1:0]    ins_src_tag,
    input  logic [NSRC-1:0]          ins_src_ok,
    input  logic                     wk_valid,
    input  logic [TAG_W-1:0]         wk_tag,
    input  logic                     rel_valid,
    input  logic [SEQ_W-1:0]         rel_seq,
    input  logic                     park_valid,
    input  logic [SEQ_W-1:0]         park_seq,
    input  logic                     replay_go,
    input  logic                     sq_valid,
    input  logic [SEQ_W-1:0]         sq_seq,
    output logic [ISSUE_W-1:0]       iss_valid,
    output logic [ISSUE_W*SEQ_W-1:0] iss_seq,
    output logic [ISSUE_W-1:0]       iss_mem,
    output logic [CNT_W-1:0]         occupancy,
    output logic                     full
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    // Entry storage.
    logic [DEPTH-1:0]      vld_q;
    pool_e                 pool_q [DEPTH];
    logic [SEQ_W-1:0]      seq_q  [DEPTH];
    logic [DEPTH-1:0]      mem_q;
    logic [NSRC*TAG_W-1:0] tag_q  [DEPTH];
    logic [NSRC-1:0]       ok_q   [DEPTH];

    logic [DEPTH*SEQ_W-1:0]   seq_flat;
    logic [DEPTH-1:0]         kill, live, sched_mask, nspec_mask;
    logic [DEPTH-1:0]         nspec_first, nspec_slot, rel_oh, issued;
    logic [DEPTH-1:0]         sched_grant;
    logic [ISSUE_W*DEPTH-1:0] sched_slot_oh;
    logic                     rel_hit;
    logic [DEPTH-1:0]         lo_oh, hi_oh, ins_oh, park_oh;
    logic                     lo_any, hi_any, ins_we, park_we;
    logic [NSRC-1:0]          ok_nxt [DEPTH];
    logic [DEPTH-1:0]         all_ok;
    logic [CNT_W-1:0]         cnt_q, cnt_d;
    logic [ISSUE_W-1:0]       iss_v_d, iss_m_d;
    logic [ISSUE_W*SEQ_W-1:0] iss_s_d;

    // True when seq is strictly younger than pivot, wrap-aware.
    function automatic logic seq_younger(input logic [SEQ_W-1:0] seq,
                                         input logic [SEQ_W-1:0] pivot);
        logic [SEQ_W-1:0] d;
        d = seq - pivot;
        return (d != '0) && !d[SEQ_W-1];
    endfunction

    // Flatten sequence numbers and classify entries by pool and squash.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            seq_flat[i*SEQ_W +: SEQ_W] = seq_q[i];
            kill[i]       = sq_valid && vld_q[i] && seq_younger(seq_q[i], sq_seq);
            live[i]       = vld_q[i] && !kill[i];
            sched_mask[i] = live[i] && (pool_q[i] == POOL_SCHED);
            nspec_mask[i] = live[i] && (pool_q[i] == POOL_NSPEC);
        end
    end

    // Oldest surviving non-speculative entry.
    iq_age_rank #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SLOTS(1)) u_nspec_oldest (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand       (nspec_mask),
        .seqs       (seq_flat),
        .skip_first (1'b0),
        .grant      (nspec_first),
        .slot_oh    (nspec_slot)
    );

    // Release hits only when the oldest non-speculative entry matches.
    always_comb begin
        for (int i = 0; i < DEPTH; i++)
            rel_oh[i] = rel_valid && nspec_first[i] && (seq_q[i] == rel_seq);
    end
    assign rel_hit = |rel_oh;

    // Oldest-first selection from the schedulable pool; release takes slot 0.
    iq_age_rank #(.DEPTH(DEPTH), .SEQ_W(SEQ_W), .SLOTS(ISSUE_W)) u_sched_sel (
        .clk        (clk),
        .rst_n      (rst_n),
        .cand       (sched_mask),
        .seqs       (seq_flat),
        .skip_first (rel_hit),
        .grant      (sched_grant),
        .slot_oh    (sched_slot_oh)
    );

    assign issued = sched_grant | rel_oh;

    // Free-entry allocation: insert takes the lowest, park the highest.
    iq_free_pick #(.DEPTH(DEPTH)) u_free (
        .busy   (vld_q),
        .lo_oh  (lo_oh),
        .hi_oh  (hi_oh),
        .lo_any (lo_any),
        .hi_any (hi_any)
    );

    assign ins_we  = ins_valid && lo_any;
    assign park_we = park_valid && hi_any && !(ins_we && (hi_oh == lo_oh));
    assign ins_oh  = ins_we  ? lo_oh : '0;
    assign park_oh = park_we ? hi_oh : '0;

    // Wakeup tracking per entry.
    for (genvar e = 0; e < DEPTH; e++) begin : g_entry
        iq_src_track #(.NSRC(NSRC), .TAG_W(TAG_W)) u_src (
            .tags     (tag_q[e]),
            .ok       (ok_q[e]),
            .wk_valid (wk_valid),
            .wk_tag   (wk_tag),
            .ok_next  (ok_nxt[e]),
            .all_ok   (all_ok[e])
        );
    end

    // Entry state update: allocate, remove (squash first, then issue), move pools.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            mem_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                pool_q[i] <= POOL_WAIT;
                seq_q[i]  <= '0;
                tag_q[i]  <= '0;
                ok_q[i]   <= '0;
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (ins_oh[i]) begin
                    vld_q[i]  <= 1'b1;
                    seq_q[i]  <= ins_seq;
                    mem_q[i]  <= ins_mem;
                    tag_q[i]  <= ins_src_tag;
                    ok_q[i]   <= ins_src_ok;
                    pool_q[i] <= ins_nspec    ? POOL_NSPEC :
                                 (&ins_src_ok) ? POOL_SCHED : POOL_WAIT;
                end else if (park_oh[i]) begin
                    vld_q[i]  <= 1'b1;
                    seq_q[i]  <= park_seq;
                    mem_q[i]  <= 1'b1;
                    tag_q[i]  <= '0;
                    ok_q[i]   <= '1;
                    pool_q[i] <= POOL_REPLAY;
                end else if (kill[i] || issued[i]) begin
                    vld_q[i] <= 1'b0;
                end else if (vld_q[i]) begin
                    ok_q[i] <= ok_nxt[i];
                    if (pool_q[i] == POOL_WAIT && all_ok[i])
                        pool_q[i] <= POOL_SCHED;
                    else if (pool_q[i] == POOL_REPLAY && replay_go)
                        pool_q[i] <= POOL_SCHED;
                end
            end
        end
    end

    // Next occupancy: add allocations, remove issued and squashed entries.
    always_comb begin
        cnt_d = cnt_q;
        if (ins_we)  cnt_d = cnt_d + 1'b1;
        if (park_we) cnt_d = cnt_d + 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            if (issued[i]) cnt_d = cnt_d - 1'b1;
            if (kill[i])   cnt_d = cnt_d - 1'b1;
        end
    end

    // Occupancy register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign occupancy = cnt_q;
    assign full      = (cnt_q == DEPTH_C);

    // Route selected entries to issue slots.
    always_comb begin
        iss_v_d = '0;
        iss_m_d = '0;
        iss_s_d = '0;
        for (int k = 0; k < ISSUE_W; k++) begin
            for (int i = 0; i < DEPTH; i++) begin
                if (sched_slot_oh[k*DEPTH + i] || (k == 0 && rel_oh[i])) begin
                    iss_v_d[k]                 = 1'b1;
                    iss_m_d[k]                 = mem_q[i];
                    iss_s_d[k*SEQ_W +: SEQ_W]  = seq_q[i];
                end
            end
        end
    end

    // Issue output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss_valid <= '0;
            iss_mem   <= '0;
            iss_seq   <= '0;
        end else begin
            iss_valid <= iss_v_d;
            iss_mem   <= iss_m_d;
            iss_seq   <= iss_s_d;
        end
    end

    // Checker state: squash point of the previous cycle, when no entry was added.
    logic             sq_only_q;
    logic [SEQ_W-1:0] sq_chk_q;
    logic             young_left;

    // Capture the last squash for the post-squash check.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sq_only_q <= 1'b0;
            sq_chk_q  <= '0;
        end else begin
            sq_only_q <= sq_valid && !ins_valid && !park_valid;
            sq_chk_q  <= sq_seq;
        end
    end

    // Any entry younger than the last squash point still present.
    always_comb begin
        young_left = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (vld_q[i] && seq_younger(seq_q[i], sq_chk_q)) young_left = 1'b1;
    end

    p_occ_tracks_r9: assert property (@(posedge clk) disable iff (!rst_n)
        occupancy == CNT_W'($countones(vld_q)));

    p_no_alloc_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !(ins_valid || park_valid));

    p_release_slot0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rel_hit |=> (iss_valid[0] && iss_seq[SEQ_W-1:0] == $past(rel_seq)));

    p_nspec_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(nspec_slot));

    p_squash_clean_r6: assert property (@(posedge clk) disable iff (!rst_n)
        sq_only_q |-> !young_left);

    for (genvar e = 0; e < DEPTH; e++) begin : g_kill_chk
        p_killed_gone_r7: assert property (@(posedge clk) disable iff (!rst_n)
            kill[e] |=> !vld_q[e]);
    end
endmodule

// File: tb/ooo_issue_queue_tb_top.sv
// Bench: directed scenarios for the issue queue, one task per scenario.
module ooo_issue_queue_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        ins_valid, ins_nspec, ins_mem;
    logic [7:0]  ins_seq;
    logic [7:0]  ins_src_tag;
    logic [1:0]  ins_src_ok;
    logic        wk_valid;
    logic [3:0]  wk_tag;
    logic        rel_valid;
    logic [7:0]  rel_seq;
    logic        park_valid;
    logic [7:0]  park_seq;
    logic        replay_go;
    logic        sq_valid;
    logic [7:0]  sq_seq;
    logic [1:0]  iss_valid;
    logic [15:0] iss_seq;
    logic [1:0]  iss_mem;
    logic [3:0]  occupancy;
    logic        full;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    ooo_issue_queue dut_i (
        .clk(clk), .rst_n(rst_n),
        .ins_valid(ins_valid), .ins_seq(ins_seq), .ins_nspec(ins_nspec),
        .ins_mem(ins_mem), .ins_src_tag(ins_src_tag), .ins_src_ok(ins_src_ok),
        .wk_valid(wk_valid), .wk_tag(wk_tag),
        .rel_valid(rel_valid), .rel_seq(rel_seq),
        .park_valid(park_valid), .park_seq(park_seq), .replay_go(replay_go),
        .sq_valid(sq_valid), .sq_seq(sq_seq),
        .iss_valid(iss_valid), .iss_seq(iss_seq), .iss_mem(iss_mem),
        .occupancy(occupancy), .full(full)
    );

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic clr_inputs();
        ins_valid = 0; ins_nspec = 0; ins_mem = 0; ins_seq = 0;
        ins_src_tag = 0; ins_src_ok = 0; wk_valid = 0; wk_tag = 0;
        rel_valid = 0; rel_seq = 0; park_valid = 0; park_seq = 0;
        replay_go = 0; sq_valid = 0; sq_seq = 0;
    endtask

    task automatic do_reset();
        clr_inputs();
        rst_n = 0;
        step();
        step();
        rst_n = 1;
    endtask

    task automatic chk_slot(input string req, input int k, input bit ev, input logic [7:0] es);
        logic       v;
        logic [7:0] s;
        v = iss_valid[k];
        s = iss_seq[k*8 +: 8];
        n_chk++;
        if (v !== ev || (ev && s !== es)) begin
            n_bad++;
            $display("FAIL %s slot %0d: got valid=%0b seq=%02h, expected valid=%0b seq=%02h",
                     req, k, v, s, ev, es);
        end
    endtask

    task automatic chk_none(input string req);
        chk_slot(req, 0, 1'b0, 8'h00);
        chk_slot(req, 1, 1'b0, 8'h00);
    endtask

    task automatic chk_occ(input string req, input int eo, input bit ef);
        n_chk++;
        if (occupancy !== 4'(eo) || full !== ef) begin
            n_bad++;
            $display("FAIL %s occupancy: got %0d full=%0b, expected %0d full=%0b",
                     req, occupancy, full, eo, ef);
        end
    endtask

    task automatic chk_mem(input string req, input int k, input bit em);
        n_chk++;
        if (iss_mem[k] !== em) begin
            n_bad++;
            $display("FAIL %s mem flag slot %0d: got %0b, expected %0b", req, k, iss_mem[k], em);
        end
    endtask

    task automatic put(input logic [7:0] s, input bit ns, input bit m,
                       input logic [3:0] t0, input bit ok0,
                       input logic [3:0] t1, input bit ok1);
        ins_valid = 1; ins_seq = s; ins_nspec = ns; ins_mem = m;
        ins_src_tag = {t1, t0}; ins_src_ok = {ok1, ok0};
        step();
        ins_valid = 0; ins_nspec = 0; ins_mem = 0;
    endtask

    task automatic wake(input logic [3:0] t);
        wk_valid = 1; wk_tag = t;
        step();
        wk_valid = 0;
    endtask

    task automatic release_nspec(input logic [7:0] s);
        rel_valid = 1; rel_seq = s;
        step();
        rel_valid = 0;
    endtask

    task automatic squash(input logic [7:0] s);
        sq_valid = 1; sq_seq = s;
        step();
        sq_valid = 0;
    endtask

    task automatic park(input logic [7:0] s);
        park_valid = 1; park_seq = s;
        step();
        park_valid = 0;
    endtask

    task automatic t_reset();
        do_reset();
        chk_none("R1");
        chk_occ("R1", 0, 0);
    endtask

    task automatic t_ready_insert();
        do_reset();
        put(8'h05, 0, 0, 4'd0, 1, 4'd0, 1);
        chk_none("R2");
        chk_occ("R9", 1, 0);
        step();
        chk_slot("R2", 0, 1, 8'h05);
        chk_slot("R2", 1, 0, 8'h00);
        chk_occ("R9", 0, 0);
    endtask

    task automatic t_wakeup();
        do_reset();
        put(8'h10, 0, 0, 4'd3, 0, 4'd4, 0);
        step();
        chk_none("R2");
        wake(4'd9);
        step();
        chk_none("R3");
        wake(4'd3);
        step();
        chk_none("R3");
        wake(4'd4);
        chk_none("R3");
        step();
        chk_slot("R3", 0, 1, 8'h10);
        chk_occ("R3", 0, 0);
    endtask

    task automatic t_order();
        do_reset();
        put(8'h20, 0, 0, 4'd1, 0, 4'd0, 1);
        put(8'h18, 0, 0, 4'd1, 0, 4'd0, 1);
        put(8'h21, 0, 0, 4'd1, 0, 4'd0, 1);
        put(8'h19, 0, 0, 4'd1, 0, 4'd0, 1);
        wake(4'd1);
        chk_none("R4");
        step();
        chk_slot("R4", 0, 1, 8'h18);
        chk_slot("R4", 1, 1, 8'h19);
        chk_occ("R9", 2, 0);
        step();
        chk_slot("R4", 0, 1, 8'h20);
        chk_slot("R4", 1, 1, 8'h21);
        chk_occ("R9", 0, 0);
    endtask

    task automatic t_wrap();
        do_reset();
        put(8'hFE, 0, 0, 4'd2, 0, 4'd0, 1);
        put(8'h01, 0, 0, 4'd2, 0, 4'd0, 1);
        put(8'hFF, 0, 0, 4'd2, 0, 4'd0, 1);
        wake(4'd2);
        step();
        chk_slot("R10", 0, 1, 8'hFE);
        chk_slot("R10", 1, 1, 8'hFF);
        step();
        chk_slot("R10", 0, 1, 8'h01);
        chk_slot("R10", 1, 0, 8'h00);
    endtask

    task automatic t_nonspec();
        do_reset();
        put(8'h30, 1, 0, 4'd0, 1, 4'd0, 1);
        put(8'h31, 1, 0, 4'd0, 1, 4'd0, 1);
        step();
        chk_none("R5");
        release_nspec(8'h31);
        chk_none("R5");
        step();
        chk_none("R5");
        chk_occ("R5", 2, 0);
        put(8'h40, 0, 0, 4'd5, 0, 4'd0, 1);
        wake(4'd5);
        release_nspec(8'h30);
        chk_slot("R5", 0, 1, 8'h30);
        chk_slot("R5", 1, 1, 8'h40);
        release_nspec(8'h31);
        chk_slot("R5", 0, 1, 8'h31);
        chk_slot("R5", 1, 0, 8'h00);
        chk_occ("R9", 0, 0);
    endtask

    task automatic t_squash();
        do_reset();
        put(8'h50, 0, 0, 4'd6, 0, 4'd0, 1);
        put(8'h51, 0, 0, 4'd6, 0, 4'd0, 1);
        put(8'h52, 0, 0, 4'd6, 0, 4'd0, 1);
        put(8'h53, 1, 0, 4'd0, 1, 4'd0, 1);
        park(8'h54);
        chk_occ("R9", 5, 0);
        squash(8'h51);
        chk_none("R6");
        chk_occ("R6", 2, 0);
        wake(4'd6);
        step();
        chk_slot("R6", 0, 1, 8'h50);
        chk_slot("R6", 1, 1, 8'h51);
        release_nspec(8'h53);
        chk_none("R6");
        replay_go = 1;
        step();
        replay_go = 0;
        step();
        chk_none("R6");
        chk_occ("R6", 0, 0);
        put(8'h60, 0, 0, 4'd0, 1, 4'd0, 1);
        squash(8'h5F);
        chk_none("R6");
        step();
        chk_none("R6");
        chk_occ("R6", 0, 0);
    endtask

    task automatic t_squash_wake();
        do_reset();
        put(8'h70, 0, 0, 4'd8, 0, 4'd0, 1);
        put(8'h71, 0, 0, 4'd8, 0, 4'd0, 1);
        sq_valid = 1; sq_seq = 8'h70; wk_valid = 1; wk_tag = 4'd8;
        step();
        sq_valid = 0; wk_valid = 0;
        chk_none("R7");
        chk_occ("R7", 1, 0);
        step();
        chk_slot("R7", 0, 1, 8'h70);
        chk_slot("R7", 1, 0, 8'h00);
        step();
        chk_none("R7");
    endtask

    task automatic t_replay();
        do_reset();
        park(8'h80);
        chk_occ("R8", 1, 0);
        step();
        step();
        chk_none("R8");
        replay_go = 1;
        step();
        replay_go = 0;
        chk_none("R8");
        step();
        chk_slot("R8", 0, 1, 8'h80);
        chk_mem("R8", 0, 1'b1);
        chk_occ("R8", 0, 0);
    endtask

    task automatic t_full();
        do_reset();
        for (int i = 0; i < 8; i++)
            put(8'(8'h90 + i), 0, 0, 4'd9, 0, 4'd0, 1);
        chk_occ("R9", 8, 1);
        wake(4'd9);
        chk_occ("R9", 8, 1);
        step();
        chk_slot("R9", 0, 1, 8'h90);
        chk_slot("R9", 1, 1, 8'h91);
        chk_occ("R9", 6, 0);
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    initial begin
        t_reset();
        t_ready_insert();
        t_wakeup();
        t_order();
        t_wrap();
        t_nonspec();
        t_squash();
        t_squash_wake();
        t_replay();
        t_full();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: run did not finish, expected completion");
            summary();
            $finish;
        end
    end
endmodule